// File: doc/BRIEF.md
# Configuration Start-up Sequencer

This block decides when a programmable device wakes up after its configuration has been loaded. A counter runs on the configuration clock while the init-done input is high. When the memory-full flag is set and the count equals the loaded length value, a single 1 is launched into a five-stage start-up register. The 1 then moves forward one stage on each clock.

Three wake-up events each follow one selectable stage of that register. The first releases the open-drain done pad. The second hands the I/O pins over to their user function. The third lifts the global set/reset. The done release always advances on the configuration clock. The I/O and reset events advance on either the configuration clock or a user clock, as chosen by a static option.

An optional synchronous mode makes the fourth stage wait until the sensed level of the wire-ANDed done pad reads high. Any device on the shared line can therefore hold every device back until all of them are ready. Once the events have fired they stay fired. Only a fresh power-on reset starts a new sequence.

Top module: `cfg_startup_seq`

## Requirements
- R1: While rst_ni is low, done_pull_low_o is 1, io_en_o is 0 and gsr_o is 1.
- R2: The counter advances on each rising cclk_i edge where init_done_i is high. The lead stage Q0 sets on the first rising cclk_i edge at which mem_full_i and init_done_i are high and the count equals len_count_i. With init high from reset release, done (tap 0) is released in cycle len_count_i+2.
- R3: No sequence starts while mem_full_i is low. A sequence also never starts if the count has already passed len_count_i when mem_full_i rises, because the comparison is an equality.
- R4: A 2-bit tap value t selects stage Q(t+1) for its event. Without a stall, stage Qk sets k clocks after Q0.
- R5: With taps done=0, io=1 and gsr=2, done releases first. The I/Os turn on one clock later, and global reset ends one clock after that.
- R6: The done release always advances on cclk_i. The I/O and global-reset stages advance on cclk_i when use_uclk_i=0 and on uclk_i when use_uclk_i=1.
- R7: When sync_done_i=1, stage Q3 sets only on an edge where done_pad_i is 1. Holding the pad low stalls Q3 and Q4, and the sequence resumes once the pad reads high.
- R8: When sync_done_i=0, done_pad_i has no effect on any output.
- R9: An event output that has fired stays fired until reset, whatever init_done_i and mem_full_i do afterwards.
- R10: With use_uclk_i=1 and no uclk_i edges, the done pad is still released, but io_en_o stays 0 and gsr_o stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cclk_i | input | 1 | Configuration clock |
| uclk_i | input | 1 | User clock for the start-up stages |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| init_done_i | input | 1 | Init signal; counting is enabled while high |
| mem_full_i | input | 1 | Configuration memory is full |
| len_count_i | input | CNT_W | Loaded length-count value |
| use_uclk_i | input | 1 | 1: the I/O and reset stages use uclk_i |
| sync_done_i | input | 1 | 1: stage Q3 waits for the done pad to read high |
| done_tap_i | input | 2 | Stage select for the done release (0..3 selects Q1..Q4) |
| io_tap_i | input | 2 | Stage select for I/O activation |
| gsr_tap_i | input | 2 | Stage select for the end of global reset |
| done_pad_i | input | 1 | Sensed level of the wire-ANDed done pad |
| done_pull_low_o | output | 1 | 1 drives the done pad low; 0 leaves it high-impedance |
| io_en_o | output | 1 | I/O pins are in their user function |
| gsr_o | output | 1 | Global set/reset is asserted |

## Verification
The bench builds the block with CNT_W=8. With that width, short length values such as 2 and 5 keep every start cycle within a few dozen clocks, and the count can also be run past the length value to show that the equality test never fires late. The user clock is produced in the bench on the falling half of the configuration clock. It can be stopped entirely, which is what makes the done-released-but-I/O-inactive state of R10 reachable.

// File: rtl/cfg_startup_pkg.sv
package cfg_startup_pkg;
  localparam int unsigned NUM_STAGES = 5;
  localparam int unsigned GATE_STAGE = 3;
  localparam int unsigned TAP_W      = $clog2(NUM_STAGES - 1);

  typedef logic [TAP_W-1:0] tap_sel_t;

  // tap 0 -> Q1 ... tap NUM_STAGES-2 -> Q(NUM_STAGES-1)
  function automatic logic pick_tap(input logic [NUM_STAGES-1:1] q, input tap_sel_t sel);
    logic r;
    r = 1'b0;
    for (int k = 1; k < NUM_STAGES; k++)
      if (int'(sel) + 1 == k) r = q[k];
    return r;
  endfunction
endpackage

// File: rtl/cfg_len_counter.sv
module cfg_len_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_done_i,
  input  logic             mem_full_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             start_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             hit;

  assign hit = mem_full_i && init_done_i && (cnt_q == len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      start_o <= 1'b0;
    end else if (!start_o) begin
      if (hit) start_o <= 1'b1;
      if (init_done_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  p_start_needs_full_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(start_o) |-> $past(mem_full_i && init_done_i));

  p_start_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> start_o);
endmodule

// File: rtl/cfg_shift_chain.sv
module cfg_shift_chain #(
  parameter int unsigned STAGES  = 5,
  parameter int unsigned GATE_AT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lead_i,
  input  logic              gate_en_i,
  input  logic              gate_lvl_i,
  output logic [STAGES-1:1] q_o
);
  logic [STAGES-1:1] nxt;

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    if (k == 1) begin : g_first
      assign nxt[k] = lead_i;
    end else if (k == GATE_AT) begin : g_gated
      assign nxt[k] = q_o[k-1] & (~gate_en_i | gate_lvl_i);
    end else begin : g_plain
      assign nxt[k] = q_o[k-1];
    end

    // OR keeps a stage set once reached, even if the gate level later drops
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o[k] <= 1'b0;
      else         q_o[k] <= q_o[k] | nxt[k];
    end

    if (k > 1) begin : g_chk
      p_thermo_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q_o[k] |-> q_o[k-1]);
    end
  end

  p_gate_stall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_en_i && !gate_lvl_i && !q_o[GATE_AT]) |=> !q_o[GATE_AT]);
endmodule

// File: rtl/cfg_startup_seq.sv
module cfg_startup_seq
  import cfg_startup_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             cclk_i,
  input  logic             uclk_i,
  input  logic             rst_ni,
  input  logic             init_done_i,
  input  logic             mem_full_i,
  input  logic [CNT_W-1:0] len_count_i,
  input  logic             use_uclk_i,
  input  logic             sync_done_i,
  input  logic [1:0]       done_tap_i,
  input  logic [1:0]       io_tap_i,
  input  logic [1:0]       gsr_tap_i,
  input  logic             done_pad_i,
  output logic             done_pull_low_o,
  output logic             io_en_o,
  output logic             gsr_o
);
  logic                    q0;
  logic                    stage_clk;
  logic [NUM_STAGES-1:1]   done_q;
  logic [NUM_STAGES-1:1]   evt_q;

  assign stage_clk = use_uclk_i ? uclk_i : cclk_i;

  cfg_len_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i       (cclk_i),
    .rst_ni      (rst_ni),
    .init_done_i (init_done_i),
    .mem_full_i  (mem_full_i),
    .len_i       (len_count_i),
    .start_o     (q0)
  );

  // done release always counted in configuration clocks
  cfg_shift_chain #(.STAGES(NUM_STAGES), .GATE_AT(GATE_STAGE)) u_done_chain (
    .clk_i      (cclk_i),
    .rst_ni     (rst_ni),
    .lead_i     (q0),
    .gate_en_i  (1'b0),
    .gate_lvl_i (1'b1),
    .q_o        (done_q)
  );

  cfg_shift_chain #(.STAGES(NUM_STAGES), .GATE_AT(GATE_STAGE)) u_evt_chain (
    .clk_i      (stage_clk),
    .rst_ni     (rst_ni),
    .lead_i     (q0),
    .gate_en_i  (sync_done_i),
    .gate_lvl_i (done_pad_i),
    .q_o        (evt_q)
  );

  assign done_pull_low_o = ~pick_tap(done_q, tap_sel_t'(done_tap_i));
  assign io_en_o         =  pick_tap(evt_q,  tap_sel_t'(io_tap_i));
  assign gsr_o           = ~pick_tap(evt_q,  tap_sel_t'(gsr_tap_i));

  p_io_needs_start_r6: assert property (@(posedge cclk_i) disable iff (!rst_ni)
    io_en_o |-> q0);
  p_done_needs_start_r2: assert property (@(posedge cclk_i) disable iff (!rst_ni)
    !done_pull_low_o |-> q0);
  p_io_sticky_r9: assert property (@(posedge cclk_i) disable iff (!rst_ni)
    io_en_o |=> io_en_o);
  p_gsr_sticky_r9: assert property (@(posedge cclk_i) disable iff (!rst_ni)
    !gsr_o |=> !gsr_o);
  p_done_sticky_r9: assert property (@(posedge cclk_i) disable iff (!rst_ni)
    !done_pull_low_o |=> !done_pull_low_o);
endmodule

// File: tb/cfg_startup_seq_bench.sv
module cfg_startup_seq_bench;
  localparam int CW = 8;

  logic cclk = 1'b0;
  logic uclk = 1'b0;
  logic uclk_run = 1'b0;
  logic rst_n = 1'b0;
  logic init_done = 1'b0;
  logic mem_full = 1'b0;
  logic [CW-1:0] len = '0;
  logic use_u = 1'b0;
  logic sync_m = 1'b0;
  logic [1:0] t_done = 2'd0, t_io = 2'd1, t_gsr = 2'd2;
  logic ext_hold = 1'b0;
  logic pull, io_en, gsr;
  logic pad;

  int n_vec = 0, n_bad = 0;
  int cyc = 0, f_done = -1, f_io = -1, f_gsr = -1;

  assign pad = !pull && !ext_hold;

  always #4 cclk = ~cclk;

  initial forever begin
    @(negedge cclk); if (uclk_run) uclk = 1'b1;
    @(posedge cclk); uclk = 1'b0;
  end

  cfg_startup_seq #(.CNT_W(CW)) u_cfg_startup_seq (
    .cclk_i(cclk), .uclk_i(uclk), .rst_ni(rst_n), .init_done_i(init_done),
    .mem_full_i(mem_full), .len_count_i(len), .use_uclk_i(use_u),
    .sync_done_i(sync_m), .done_tap_i(t_done), .io_tap_i(t_io), .gsr_tap_i(t_gsr),
    .done_pad_i(pad), .done_pull_low_o(pull), .io_en_o(io_en), .gsr_o(gsr));

  // reference model
  int  m_cnt = 0;
  bit  m_q0 = 0;
  int  m_age = 0;
  int  m_lvl = 0;
  logic m_sclk;
  assign m_sclk = use_u ? uclk : cclk;

  always @(posedge cclk or negedge rst_n) begin
    if (!rst_n) begin m_cnt <= 0; m_q0 <= 0; m_age <= 0; end
    else begin
      if (m_q0 && m_age < 8) m_age <= m_age + 1;
      if (!m_q0) begin
        if (mem_full && init_done && m_cnt == int'(len)) m_q0 <= 1;
        if (init_done && m_cnt < 255) m_cnt <= m_cnt + 1;
      end
    end
  end

  always @(posedge m_sclk or negedge rst_n) begin
    if (!rst_n) m_lvl <= 0;
    else if (m_lvl == 0) begin
      if (m_q0) m_lvl <= 1;
    end else if (m_lvl < 4) begin
      if (!(m_lvl == 2 && sync_m && !pad)) m_lvl <= m_lvl + 1;
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0b expected %0b", tag, cyc, act, exp);
    end
  endtask

  task automatic chk_int(input int act, input int exp, input string tag);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge cclk) begin
    #2;
    if (rst_n) begin
      cyc++;
      if (f_done < 0 && !pull) f_done = cyc;
      if (f_io < 0 && io_en) f_io = cyc;
      if (f_gsr < 0 && !gsr) f_gsr = cyc;
    end
    chk(pull, !(m_age >= int'(t_done) + 1), "R4 done_pull_low model");
    chk(io_en, (m_lvl >= int'(t_io) + 1), "R6 io_en model");
    chk(gsr, !(m_lvl >= int'(t_gsr) + 1), "R7 gsr model");
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge cclk);
  endtask

  task automatic start(input int l, input bit mf, input bit ini, input logic [1:0] td,
                       input logic [1:0] ti, input logic [1:0] tg, input bit uu,
                       input bit sy, input bit ur);
    @(negedge cclk);
    rst_n = 1'b0;
    len = CW'(l); mem_full = mf; init_done = ini;
    t_done = td; t_io = ti; t_gsr = tg; use_u = uu; sync_m = sy; uclk_run = ur;
    ext_hold = 1'b0;
    cycles(2);
    chk(pull, 1'b1, "R1 reset done pulled low");
    chk(io_en, 1'b0, "R1 reset io off");
    chk(gsr, 1'b1, "R1 reset gsr on");
    cyc = 0; f_done = -1; f_io = -1; f_gsr = -1;
    rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    // S1: default ordering, len 5
    start(5, 1, 1, 2'd0, 2'd1, 2'd2, 0, 0, 0);
    cycles(20);
    chk_int(f_done, 7, "R2 done release cycle");
    chk_int(f_io, f_done + 1, "R5 io one clock after done");
    chk_int(f_gsr, f_io + 1, "R5 gsr one clock after io");
    mem_full = 0; init_done = 0;
    cycles(10);
    chk(pull, 1'b0, "R9 done stays released");
    chk(io_en, 1'b1, "R9 io stays on");
    chk(gsr, 1'b0, "R9 gsr stays off");

    // S2: init low for 10 cycles delays the count
    start(5, 1, 0, 2'd0, 2'd1, 2'd2, 0, 0, 0);
    cycles(10); init_done = 1;
    cycles(20);
    chk_int(f_done, 17, "R2 count waits for init");

    // S3: memory not full, then full after count passed
    start(3, 0, 1, 2'd0, 2'd1, 2'd2, 0, 0, 0);
    cycles(15);
    chk(pull, 1'b1, "R3 no start without mem_full");
    mem_full = 1;
    cycles(15);
    chk(pull, 1'b1, "R3 no start once count passed");
    chk(gsr, 1'b1, "R3 gsr held");

    // S4: remapped taps
    start(2, 1, 1, 2'd3, 2'd0, 2'd0, 0, 0, 0);
    cycles(15);
    chk_int(f_io, 4, "R4 io on Q1");
    chk_int(f_done, 7, "R4 done on Q4");
    chk_int(f_gsr, 4, "R4 gsr on Q1");

    // S5: synchronous mode, pad held low externally
    start(2, 1, 1, 2'd0, 2'd1, 2'd2, 0, 1, 0);
    ext_hold = 1;
    cycles(20);
    chk(io_en, 1'b1, "R7 io ahead of stall");
    chk(gsr, 1'b1, "R7 gsr stalled by pad");
    ext_hold = 0;
    cycles(6);
    chk(gsr, 1'b0, "R7 gsr after pad release");

    // S6: non-synchronous mode ignores the pad
    start(2, 1, 1, 2'd0, 2'd1, 2'd3, 0, 0, 0);
    ext_hold = 1;
    cycles(15);
    chk_int(f_gsr, 7, "R8 gsr timing with pad held");
    chk(io_en, 1'b1, "R8 io with pad held");

    // S7: user clock running
    start(4, 1, 1, 2'd0, 2'd1, 2'd2, 1, 0, 1);
    cycles(20);
    chk(pull, 1'b0, "R6 done on user clock run");
    chk(io_en, 1'b1, "R6 io on user clock");
    chk(gsr, 1'b0, "R6 gsr on user clock");

    // S8: user clock selected but absent
    start(4, 1, 1, 2'd0, 2'd1, 2'd2, 1, 0, 0);
    cycles(40);
    chk(pull, 1'b0, "R10 done released on cclk");
    chk(io_en, 1'b0, "R10 io never active");
    chk(gsr, 1'b1, "R10 gsr never released");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule